// File: doc/BRIEF.md
# Hierarchical Carry-Lookahead Adder, 16 Bits

This block adds two 16-bit unsigned or two's-complement operands plus a carry-in bit, and returns the 16-bit sum and the carry leaving the top bit. It is purely combinational. The operands are cut into four nibble-wide groups. Each group makes its own inner carries from its own carry-in, with every carry written as one flat AND-OR of bit generate and propagate terms. Each group also reports whether it creates a carry by itself and whether it would pass an incoming carry straight through.

A second lookahead stage combines those four group summaries with the external carry-in. It produces the carry into each group and the final carry-out in one flat level, so no carry ever travels through a chain of groups. The summary of the whole 16-bit word is also driven out on two pins. A wider adder can therefore put four of these blocks under one more lookahead stage of the same kind.

Top module: `cla16_adder`

## Requirements
- R1: `sum_o` equals the low 16 bits of `a_i + b_i + c_i`, and equals 0 when all inputs are 0.
- R2: `c_o` equals bit 16 of `a_i + b_i + c_i` taken as a 17-bit sum.
- R3: `grp_gen_o` is 1 exactly when `a_i + b_i`, with no carry-in, overflows 16 bits. It does not depend on `c_i`.
- R4: `grp_prop_o` is 1 exactly when `a_i` and `b_i` differ in every one of the 16 bit positions, that is `a_i ^ b_i == 16'hFFFF`.
- R5: `c_o` always equals `grp_gen_o | (grp_prop_o & c_i)`, so that several blocks can be cascaded. `grp_gen_o` and `grp_prop_o` are never 1 together.
- R6: The carry into bit positions 4, 8 and 12 is correct for every combination of the lower groups. Each lower group may kill, create or pass a carry, and `c_i` may be 0 or 1. Any such carry error shows up in `sum_o`.
- R7: The block holds no state. `sum_o`, `c_o`, `grp_gen_o` and `grp_prop_o` follow new inputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| c_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| c_o | output | 1 | Carry out of bit 15 |
| grp_gen_o | output | 1 | Whole-word carry generate |
| grp_prop_o | output | 1 | Whole-word carry propagate |

## Verification
One nibble at a time is swept over all 256 operand pairs, with both carry-in values. The nibble below it is set to either create or kill a carry, and the groups above it are set to pass a carry. This separates a wrong inner-group carry from a wrong carry at a group boundary, and it shows whether a carry reaches `c_o` through every propagating group. A second sweep sets each of the four groups to kill, create or pass, across all 81 combinations and both carry-in values. This drives every product term of the second-level stage and of the word summary. Random operands then check sum, carry-out and the summary pins together. Each vector is sampled one time unit after the inputs change, which confirms that no clock edge is needed.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int CLA_GRP_W = 4;
  localparam int CLA_N_GRP = 4;
endpackage

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
  parameter int N = 4
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prop_i,
  input  logic         cin_i,
  output logic [N:1]   carry_o,
  output logic         blk_gen_o,
  output logic         blk_prop_o
);
  for (genvar i = 0; i < N; i++) begin : g_carry
    logic c_flat;
    always_comb begin
      logic term;
      logic all_p;
      c_flat = 1'b0;
      for (int j = 0; j <= i; j++) begin
        term = gen_i[j];
        for (int k = j + 1; k <= i; k++) term = term & prop_i[k];
        c_flat = c_flat | term;
      end
      all_p = cin_i;
      for (int k = 0; k <= i; k++) all_p = all_p & prop_i[k];
      c_flat = c_flat | all_p;
    end
    assign carry_o[i+1] = c_flat;
  end

  always_comb begin
    logic term;
    blk_gen_o = 1'b0;
    for (int j = 0; j < N; j++) begin
      term = gen_i[j];
      for (int k = j + 1; k < N; k++) term = term & prop_i[k];
      blk_gen_o = blk_gen_o | term;
    end
  end

  assign blk_prop_o = &prop_i;

  // R5: the flat top carry agrees with the separately formed summary pair
  always_comb begin
    a_r5_cascade: assert (carry_o[N] == (blk_gen_o | (blk_prop_o & cin_i)))
      else $error("a_r5_cascade");
  end
endmodule

// File: rtl/cla_group.sv
module cla_group #(
  parameter int GW = 4
) (
  input  logic [GW-1:0] a_i,
  input  logic [GW-1:0] b_i,
  input  logic          cin_i,
  output logic [GW-1:0] sum_o,
  output logic          grp_gen_o,
  output logic          grp_prop_o
);
  logic [GW-1:0] bit_g;
  logic [GW-1:0] bit_p;
  logic [GW:1]   carry;
  logic [GW-1:0] carry_in_vec;

  for (genvar i = 0; i < GW; i++) begin : g_bit
    assign bit_g[i] = a_i[i] & b_i[i];
    assign bit_p[i] = a_i[i] ^ b_i[i];
  end

  cla_lookahead #(.N(GW)) u_la (
    .gen_i     (bit_g),
    .prop_i    (bit_p),
    .cin_i     (cin_i),
    .carry_o   (carry),
    .blk_gen_o (grp_gen_o),
    .blk_prop_o(grp_prop_o)
  );

  if (GW > 1) begin : g_cvec
    assign carry_in_vec = {carry[GW-1:1], cin_i};
  end else begin : g_cvec1
    assign carry_in_vec = cin_i;
  end

  assign sum_o = bit_p ^ carry_in_vec;

  // R4: a fully propagating group hands its carry-in straight out
  always_comb begin
    if (grp_prop_o) begin
      a_r4_pass_through: assert (carry[GW] == cin_i) else $error("a_r4_pass_through");
    end
  end

  // R5: XOR propagate makes generate and propagate exclusive
  always_comb begin
    a_r5_exclusive: assert (!(grp_gen_o && grp_prop_o)) else $error("a_r5_exclusive");
  end
endmodule

// File: rtl/cla16_adder.sv
module cla16_adder
  import cla_pkg::*;
#(
  parameter  int GRP_W = CLA_GRP_W,
  parameter  int N_GRP = CLA_N_GRP,
  localparam int W     = GRP_W * N_GRP
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] sum_o,
  output logic         c_o,
  output logic         grp_gen_o,
  output logic         grp_prop_o
);
  logic [N_GRP-1:0] g_gen;
  logic [N_GRP-1:0] g_prop;
  logic [N_GRP-1:0] g_cin;
  logic [N_GRP:1]   top_carry;

  for (genvar k = 0; k < N_GRP; k++) begin : g_grp
    if (k == 0) begin : g_first
      assign g_cin[k] = c_i;
    end else begin : g_rest
      assign g_cin[k] = top_carry[k];
    end

    cla_group #(.GW(GRP_W)) u_grp (
      .a_i       (a_i[k*GRP_W +: GRP_W]),
      .b_i       (b_i[k*GRP_W +: GRP_W]),
      .cin_i     (g_cin[k]),
      .sum_o     (sum_o[k*GRP_W +: GRP_W]),
      .grp_gen_o (g_gen[k]),
      .grp_prop_o(g_prop[k])
    );
  end

  cla_lookahead #(.N(N_GRP)) u_top_la (
    .gen_i     (g_gen),
    .prop_i    (g_prop),
    .cin_i     (c_i),
    .carry_o   (top_carry),
    .blk_gen_o (grp_gen_o),
    .blk_prop_o(grp_prop_o)
  );

  assign c_o = top_carry[N_GRP];

  // R1, R2: the assembled result matches the arithmetic sum
  always_comb begin
    a_r1_r2_sum: assert ({c_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, c_i}))
      else $error("a_r1_r2_sum");
  end

  // R4: word propagate means every bit pair differs
  always_comb begin
    a_r4_word_prop: assert (grp_prop_o == ((a_i ^ b_i) == {W{1'b1}}))
      else $error("a_r4_word_prop");
  end
endmodule

// File: tb/cla16_adder_bench.sv
module cla16_adder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] a, b;
  logic cin;
  logic [15:0] sum;
  logic cout, ggen, gprop;
  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cla16_adder u_cla16_adder (
    .a_i(a), .b_i(b), .c_i(cin),
    .sum_o(sum), .c_o(cout), .grp_gen_o(ggen), .grp_prop_o(gprop)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s a=%h b=%h cin=%0d actual=%h expected=%h", req, a, b, cin, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] av, input logic [15:0] bv, input logic cv, input string tag);
    logic [16:0] full;
    logic [16:0] nocarry;
    @(posedge clk);
    a = av; b = bv; cin = cv;
    #1; // R7: sampled one unit later, no clock edge in between
    full    = {1'b0, av} + {1'b0, bv} + {16'd0, cv};
    nocarry = {1'b0, av} + {1'b0, bv};
    chk({"R1 ", tag}, {16'd0, sum}, {16'd0, full[15:0]});
    chk({"R2 ", tag}, {31'd0, cout}, {31'd0, full[16]});
    chk("R3", {31'd0, ggen}, {31'd0, nocarry[16]});
    chk("R4", {31'd0, gprop}, {31'd0, ((av ^ bv) == 16'hFFFF)});
    chk("R5", {31'd0, cout}, {31'd0, ggen | (gprop & cv)});
    chk("R5 excl", {31'd0, ggen & gprop}, 32'd0);
    @(negedge clk);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > WD_LIMIT) begin
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WD_LIMIT);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    a = '0; b = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    // R1: idle state with zero inputs
    chk("R1 zero", {15'd0, cout, sum}, 32'd0);
    chk("R3 zero", {31'd0, ggen}, 32'd0);
    chk("R4 zero", {31'd0, gprop}, 32'd0);

    // R6: each nibble exhaustive, lower group creates or kills, upper groups pass
    for (int k = 0; k < 4; k++) begin
      for (int lowgen = 0; lowgen < 2; lowgen++) begin
        for (int an = 0; an < 16; an++) begin
          for (int bn = 0; bn < 16; bn++) begin
            for (int c = 0; c < 2; c++) begin
              logic [15:0] av, bv;
              av = 16'hFFFF; bv = 16'h0000;
              av[k*4 +: 4] = an[3:0];
              bv[k*4 +: 4] = bn[3:0];
              if (k > 0) begin
                av[(k-1)*4 +: 4] = lowgen ? 4'hF : 4'h0;
                bv[(k-1)*4 +: 4] = lowgen ? 4'h1 : 4'h0;
              end
              apply(av, bv, c[0], "R6 nibble sweep");
            end
          end
        end
      end
    end

    // R6: every kill/create/pass mix across the four groups
    for (int m = 0; m < 81; m++) begin
      for (int c = 0; c < 2; c++) begin
        logic [15:0] av, bv;
        int r;
        r = m;
        for (int k = 0; k < 4; k++) begin
          case (r % 3)
            0: begin av[k*4 +: 4] = 4'h0; bv[k*4 +: 4] = 4'h0; end
            1: begin av[k*4 +: 4] = 4'hA; bv[k*4 +: 4] = 4'h5; end
            default: begin av[k*4 +: 4] = 4'h8; bv[k*4 +: 4] = 4'h9; end
          endcase
          r = r / 3;
        end
        apply(av, bv, c[0], "R6 group mix");
      end
    end

    // R1-style edge operands and random operands
    apply(16'hFFFF, 16'h0000, 1'b1, "full propagate");
    apply(16'hFFFF, 16'hFFFF, 1'b1, "max");
    apply(16'h8000, 16'h8000, 1'b0, "top generate");
    for (int i = 0; i < 3000; i++) begin
      apply($urandom, $urandom, 1'($urandom), "random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule